// File: doc/BRIEF.md
# LPC Host Cycle Generator

This block is the host side of a Low Pin Count bus. A single request (cycle kind, address, size and write data) is turned into a complete bus cycle on the 4-bit LAD lines with the active-low frame strobe. Four cycle kinds are supported: IO read, IO write, firmware read and firmware write. The host sends the start nibble and the header nibbles. For a write it also sends the data. It then hands the bus to the target and samples sync codes until the target reports ready or error. On a ready read it collects the data nibbles. The cycle ends with the target's closing turnaround.

The block is meant for driving a peripheral-side target in a system, or for exercising one in a test environment. Wait syncs may last any number of clocks up to a limit set by a parameter. When that limit runs out, the host holds the frame strobe low with LAD at 1111 for a few clocks to abort the cycle. It then reports an error. The response port gives a one-clock done pulse. The error flag and the read data are valid on that same clock.

Top module: `lpc_host_gen`

## Requirements
- R1: A synchronous active-high reset, from any state, leaves the host idle: `lframe_n` high, `lad_oe` low, `req_ready` high and `rsp_done` low on the clock after reset is sampled.
- R2: An accepted request (`req_valid` while `req_ready`) drives `lframe_n` low for exactly one clock on the next clock, with LAD carrying 0000 for IO kinds, 1101 for a firmware read and 1110 for a firmware write. Kind codes: 0 IO read, 1 IO write, 2 firmware read, 3 firmware write.
- R3: An IO cycle sends a cycle-type nibble (0000 read, 0010 write) and then address bits 15:0 as four nibbles, most significant first. IO data is always one byte (two nibbles), whatever `req_size` holds, and read data is zero-extended from 8 bits.
- R4: A firmware cycle sends the IDSEL nibble (parameter, default 0000), then address bits 27:0 as seven nibbles most significant first, then a size nibble: `req_size` 0 gives 0000 (1 byte), 1 gives 0001 (2 bytes), and 2 or 3 give 0010 (4 bytes).
- R5: Data nibbles move least significant first. Write data is taken from `req_wdata`. Read data is assembled into `rsp_rdata`, zero-extended above the transferred size. A write reports zero read data.
- R6: In the first turnaround clock after the header (or the write data) the host drives 1111. From the second turnaround clock through sync, read data and the target's two-clock closing turnaround, `lad_oe` stays low.
- R7: A sync code of 0000 ends the wait. Any other code except 1010 (including short wait 0101 and long wait 0110) keeps the host sampling. A ready read is followed by its data nibbles and then the closing turnaround. A ready write is followed only by the closing turnaround.
- R8: A 1010 sync skips the data phase. After the two closing turnaround clocks, the host completes with `rsp_error` high and `rsp_rdata` zero.
- R9: If SYNC_TIMEOUT sync clocks (default 64) pass with no ready or error code, the host drives `lframe_n` low with LAD 1111 and `lad_oe` high for ABORT_LEN clocks (default 4). It then completes with an error. A ready or error code in the last permitted sync clock is honoured.
- R10: `rsp_done` is a one-clock pulse in the clock after the last closing turnaround (or abort) clock, with `rsp_error` on that same clock. `req_ready` is high only while idle, and a request offered during a cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Host idle, request taken this clock |
| req_kind | input | 2 | Cycle kind: 0 IO rd, 1 IO wr, 2 FW rd, 3 FW wr |
| req_addr | input | 28 | Address (IO uses bits 15:0) |
| req_size | input | 2 | Firmware size: 0 one byte, 1 two bytes, 2/3 four bytes |
| req_wdata | input | 32 | Write data |
| lad_in | input | 4 | LAD value seen on the bus |
| lad_out | output | 4 | LAD value the host drives |
| lad_oe | output | 1 | Host drives LAD |
| lframe_n | output | 1 | Active-low frame strobe |
| rsp_done | output | 1 | Cycle complete pulse |
| rsp_error | output | 1 | Error sync or timeout, valid with done |
| rsp_rdata | output | 32 | Read data, valid with done |

## Verification
The sync timeout and an arriving terminal sync code can land on the same clock, the last one the limit allows. One read is given exactly 63 wait codes, which puts its ready code on the 64th sync clock. That read must complete normally with its data, at the clock counted from the wait length. A second read gets 64 wait codes and must abort with the frame strobe low and report an error. Both runs are checked at the bus pins nibble by nibble and at the done clock.

// File: rtl/lpch_pkg.sv
package lpch_pkg;

    localparam int ADDR_W    = 28;
    localparam int IO_ADDR_W = 16;
    localparam int DATA_W    = 32;
    localparam int NIB_W     = 4;

    localparam int IO_HDR_LEN = 1 + IO_ADDR_W / NIB_W;   // type + address
    localparam int FW_HDR_LEN = 2 + ADDR_W / NIB_W;      // idsel + address + size

    localparam logic [3:0] SYNC_READY = 4'h0;
    localparam logic [3:0] SYNC_SHORT = 4'h5;
    localparam logic [3:0] SYNC_LONG  = 4'h6;
    localparam logic [3:0] SYNC_ERR   = 4'hA;
    localparam logic [3:0] NIB_IDLE   = 4'hF;

    localparam logic [3:0] START_IO   = 4'h0;
    localparam logic [3:0] START_FWRD = 4'hD;
    localparam logic [3:0] START_FWWR = 4'hE;

    typedef enum logic [1:0] {
        K_IO_RD = 2'd0,
        K_IO_WR = 2'd1,
        K_FW_RD = 2'd2,
        K_FW_WR = 2'd3
    } lpch_kind_e;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_HDR, S_WDATA, S_HTAR,
        S_SYNC, S_RDATA, S_TTAR, S_ABORT
    } lpch_state_e;

    typedef struct packed {
        lpch_kind_e        kind;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        size;
    } lpch_req_t;

    function automatic logic kind_is_fw(input lpch_kind_e k);
        return k[1];
    endfunction

    function automatic logic kind_is_wr(input lpch_kind_e k);
        return k[0];
    endfunction

    function automatic logic [3:0] start_nibble(input lpch_kind_e k);
        case (k)
            K_FW_RD: return START_FWRD;
            K_FW_WR: return START_FWWR;
            default: return START_IO;
        endcase
    endfunction

    function automatic logic [3:0] msize_nibble(input logic [1:0] sz);
        case (sz)
            2'd0:    return 4'h0;
            2'd1:    return 4'h1;
            default: return 4'h2;
        endcase
    endfunction

    function automatic logic [3:0] hdr_len(input lpch_kind_e k);
        return kind_is_fw(k) ? 4'(FW_HDR_LEN) : 4'(IO_HDR_LEN);
    endfunction

    function automatic logic [3:0] data_len(input lpch_kind_e k, input logic [1:0] sz);
        if (!kind_is_fw(k)) return 4'd2;
        case (sz)
            2'd0:    return 4'd2;
            2'd1:    return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/lpch_hdr_mux.sv
module lpch_hdr_mux
    import lpch_pkg::*;
#(
    parameter logic [3:0] IDSEL = 4'h0
) (
    input  lpch_req_t  req,
    input  logic [3:0] idx,
    output logic [3:0] nib
);
    logic [3:0] io_nib [IO_HDR_LEN];
    logic [3:0] fw_nib [FW_HDR_LEN];

    assign io_nib[0] = {2'b00, kind_is_wr(req.kind), 1'b0};
    assign fw_nib[0] = IDSEL;
    assign fw_nib[FW_HDR_LEN-1] = msize_nibble(req.size);

    for (genvar g = 0; g < IO_HDR_LEN - 1; g++) begin : g_io
        assign io_nib[g+1] = req.addr[IO_ADDR_W-1-NIB_W*g -: NIB_W];
    end

    for (genvar g = 0; g < FW_HDR_LEN - 2; g++) begin : g_fw
        assign fw_nib[g+1] = req.addr[ADDR_W-1-NIB_W*g -: NIB_W];
    end

    always_comb begin
        nib = NIB_IDLE;
        if (kind_is_fw(req.kind)) begin
            for (int i = 0; i < FW_HDR_LEN; i++)
                if (idx == 4'(i)) nib = fw_nib[i];
        end else begin
            for (int i = 0; i < IO_HDR_LEN; i++)
                if (idx == 4'(i)) nib = io_nib[i];
        end
    end
endmodule

// File: rtl/lpch_data_reg.sv
module lpch_data_reg
    import lpch_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          cap,
    input  logic [3:0]    idx,
    input  logic [3:0]    cap_nib,
    output logic [3:0]    out_nib,
    output logic [DW-1:0] data_q
);
    localparam int NIBS = DW / NIB_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (load) begin
            data_q <= load_val;
        end else if (cap) begin
            for (int i = 0; i < NIBS; i++)
                if (idx == 4'(i)) data_q[i*NIB_W +: NIB_W] <= cap_nib;
        end
    end

    always_comb begin
        out_nib = NIB_IDLE;
        for (int i = 0; i < NIBS; i++)
            if (idx == 4'(i)) out_nib = data_q[i*NIB_W +: NIB_W];
    end

    AST_CAP_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        cap |-> !load);  // R5
endmodule

// File: rtl/lpch_sync_timer.sv
module lpch_sync_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expire = run && (cnt_q == LAST);

    AST_EXPIRE_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        expire |-> $past(run));  // R9
endmodule

// File: rtl/lpc_host_gen.sv
module lpc_host_gen
    import lpch_pkg::*;
#(
    parameter int         SYNC_TIMEOUT = 64,
    parameter int         ABORT_LEN    = 4,
    parameter logic [3:0] FW_IDSEL     = 4'h0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_kind,
    input  logic [27:0] req_addr,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_wdata,
    input  logic [3:0]  lad_in,
    output logic [3:0]  lad_out,
    output logic        lad_oe,
    output logic        lframe_n,
    output logic        rsp_done,
    output logic        rsp_error,
    output logic [31:0] rsp_rdata
);
    localparam int SEQ_W = (ABORT_LEN > 15) ? $clog2(ABORT_LEN + 1) : 4;
    localparam logic [SEQ_W-1:0] ABORT_LAST = SEQ_W'(ABORT_LEN - 1);

    lpch_state_e       state_q;
    logic [SEQ_W-1:0]  seq_q;
    lpch_req_t         req_q;
    logic              err_q;
    logic              expire;
    logic [3:0]        hdr_nib;
    logic [3:0]        dat_nib;
    logic [DATA_W-1:0] data_q;
    logic              accept;
    logic              is_wr;
    logic [SEQ_W-1:0]  hdr_last;
    logic [SEQ_W-1:0]  dat_last;

    assign accept   = (state_q == S_IDLE) && req_valid;
    assign is_wr    = kind_is_wr(req_q.kind);
    assign hdr_last = SEQ_W'(hdr_len(req_q.kind) - 4'd1);
    assign dat_last = SEQ_W'(data_len(req_q.kind, req_q.size) - 4'd1);

    lpch_hdr_mux #(.IDSEL(FW_IDSEL)) u_hdr (
        .req (req_q),
        .idx (seq_q[3:0]),
        .nib (hdr_nib)
    );

    lpch_data_reg #(.DW(DATA_W)) u_data (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (kind_is_wr(lpch_kind_e'(req_kind)) ? req_wdata : '0),
        .cap      (state_q == S_RDATA),
        .idx      (seq_q[3:0]),
        .cap_nib  (lad_in),
        .out_nib  (dat_nib),
        .data_q   (data_q)
    );

    lpch_sync_timer #(.LIMIT(SYNC_TIMEOUT)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (state_q == S_SYNC),
        .expire (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            seq_q     <= '0;
            req_q     <= '0;
            err_q     <= 1'b0;
            rsp_done  <= 1'b0;
            rsp_error <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done  <= 1'b0;
            rsp_error <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        req_q   <= '{kind: lpch_kind_e'(req_kind), addr: req_addr, size: req_size};
                        err_q   <= 1'b0;
                        seq_q   <= '0;
                        state_q <= S_START;
                    end
                end
                S_START: begin
                    seq_q   <= '0;
                    state_q <= S_HDR;
                end
                S_HDR: begin
                    if (seq_q == hdr_last) begin
                        seq_q   <= '0;
                        state_q <= is_wr ? S_WDATA : S_HTAR;
                    end else begin
                        seq_q <= seq_q + 1'b1;
                    end
                end
                S_WDATA: begin
                    if (seq_q == dat_last) begin
                        seq_q   <= '0;
                        state_q <= S_HTAR;
                    end else begin
                        seq_q <= seq_q + 1'b1;
                    end
                end
                S_HTAR: begin
                    if (seq_q == SEQ_W'(1)) begin
                        seq_q   <= '0;
                        state_q <= S_SYNC;
                    end else begin
                        seq_q <= seq_q + 1'b1;
                    end
                end
                S_SYNC: begin
                    seq_q <= '0;
                    if (lad_in == SYNC_READY) begin
                        state_q <= is_wr ? S_TTAR : S_RDATA;
                    end else if (lad_in == SYNC_ERR) begin
                        err_q   <= 1'b1;
                        state_q <= S_TTAR;
                    end else if (expire) begin
                        state_q <= S_ABORT;
                    end
                end
                S_RDATA: begin
                    if (seq_q == dat_last) begin
                        seq_q   <= '0;
                        state_q <= S_TTAR;
                    end else begin
                        seq_q <= seq_q + 1'b1;
                    end
                end
                S_TTAR: begin
                    if (seq_q == SEQ_W'(1)) begin
                        seq_q     <= '0;
                        state_q   <= S_IDLE;
                        rsp_done  <= 1'b1;
                        rsp_error <= err_q;
                        rsp_rdata <= (err_q || is_wr) ? '0 : data_q;
                    end else begin
                        seq_q <= seq_q + 1'b1;
                    end
                end
                S_ABORT: begin
                    if (seq_q == ABORT_LAST) begin
                        seq_q     <= '0;
                        state_q   <= S_IDLE;
                        rsp_done  <= 1'b1;
                        rsp_error <= 1'b1;
                        rsp_rdata <= '0;
                    end else begin
                        seq_q <= seq_q + 1'b1;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        lframe_n  = 1'b1;
        lad_oe    = 1'b0;
        lad_out   = NIB_IDLE;
        req_ready = 1'b0;
        case (state_q)
            S_IDLE:  req_ready = 1'b1;
            S_START: begin
                lframe_n = 1'b0;
                lad_oe   = 1'b1;
                lad_out  = start_nibble(req_q.kind);
            end
            S_HDR: begin
                lad_oe  = 1'b1;
                lad_out = hdr_nib;
            end
            S_WDATA: begin
                lad_oe  = 1'b1;
                lad_out = dat_nib;
            end
            S_HTAR:  lad_oe = (seq_q == '0);
            S_ABORT: begin
                lframe_n = 1'b0;
                lad_oe   = 1'b1;
            end
            default: ;
        endcase
    end

    AST_START_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!lframe_n && lad_oe));  // R2
    AST_START_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        (!lframe_n && lad_out != NIB_IDLE) |=> lframe_n);  // R2
    AST_NO_REDRIVE: assert property (@(posedge clk) disable iff (rst)
        (!lad_oe && !req_ready) |=> (!lad_oe || !lframe_n));  // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);  // R10
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        rsp_error |-> rsp_done);  // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (lframe_n && !lad_oe));  // R10
    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        rsp_error |-> (rsp_rdata == '0));  // R8
endmodule

// File: tb/lpc_host_gen_bench.sv
`timescale 1ns/1ps
module lpc_host_gen_bench;

    localparam int TMO   = 64;
    localparam int ABORT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = '0;
    logic [27:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  lad_in = 4'hF;
    logic [3:0]  lad_out;
    logic        lad_oe;
    logic        lframe_n;
    logic        rsp_done;
    logic        rsp_error;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lpc_host_gen u_lpc_host_gen (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .lad_in(lad_in), .lad_out(lad_out), .lad_oe(lad_oe), .lframe_n(lframe_n),
        .rsp_done(rsp_done), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata)
    );

    typedef struct packed {
        logic [1:0]  kind;
        logic [27:0] addr;
        logic [1:0]  size;
        logic [31:0] wdata;
        logic [7:0]  nwait;
        logic [3:0]  wcode;
        logic [3:0]  code;
        logic [31:0] tdata;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VT [NV] = '{
        '{2'd0, 28'h000_1234, 2'd0, 32'h0000_0000, 8'd0,  4'h6, 4'h0, 32'h0000_005A},
        '{2'd1, 28'h000_0080, 2'd0, 32'hFFFF_FFC3, 8'd3,  4'h5, 4'h0, 32'h0000_0000},
        '{2'd2, 28'hABC_DEF1, 2'd2, 32'h0000_0000, 8'd5,  4'h6, 4'h0, 32'h89AB_CDEF},
        '{2'd3, 28'h012_3456, 2'd1, 32'h1234_BEEF, 8'd1,  4'hC, 4'h0, 32'h0000_0000},
        '{2'd2, 28'h765_4321, 2'd0, 32'h0000_0000, 8'd2,  4'h6, 4'hA, 32'h0000_0077},
        '{2'd1, 28'h000_03F8, 2'd0, 32'h0000_0011, 8'd0,  4'h6, 4'hA, 32'h0000_0000},
        '{2'd3, 28'hFED_CBA9, 2'd2, 32'h1357_9BDF, 8'd0,  4'h6, 4'h0, 32'h0000_0000},
        '{2'd0, 28'h000_F00D, 2'd2, 32'h0000_0000, 8'd63, 4'h6, 4'h0, 32'hDEAD_BE96},
        '{2'd2, 28'h100_0000, 2'd1, 32'h0000_0000, 8'd64, 4'h6, 4'h0, 32'h0000_0000},
        '{2'd2, 28'h055_AA55, 2'd3, 32'h0000_0000, 8'd2,  4'h5, 4'h0, 32'hCAFE_F00D}
    };

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input bit poke);
        logic [3:0]  hn [9];
        int          hl, dl, nsync;
        bit          fw, wr, to, er;
        logic [31:0] exp_rd, mask;
        logic [3:0]  st;
        int          bad_hdr = 0, bad_wd = 0, bad_tar = 0, bad_quiet = 0, bad_abort = 0;
        string       dtag, rtag;

        fw = v.kind[1];
        wr = v.kind[0];
        to = (int'(v.nwait) >= TMO);
        er = to || (v.code == 4'hA);
        if (fw) begin
            hl = 9;
            dl = (v.size == 2'd0) ? 2 : (v.size == 2'd1) ? 4 : 8;
            hn[0] = 4'h0;
            for (int i = 0; i < 7; i++) hn[i+1] = v.addr[27-4*i -: 4];
            hn[8] = (v.size == 2'd0) ? 4'h0 : (v.size == 2'd1) ? 4'h1 : 4'h2;
            st = wr ? 4'hE : 4'hD;
        end else begin
            hl = 5;
            dl = 2;
            hn[0] = wr ? 4'h2 : 4'h0;
            for (int i = 0; i < 4; i++) hn[i+1] = v.addr[15-4*i -: 4];
            st = 4'h0;
        end
        mask   = (dl == 8) ? 32'hFFFF_FFFF : ((32'h1 << (4*dl)) - 1);
        exp_rd = (er || wr) ? 32'h0 : (v.tdata & mask);
        dtag   = to ? "R9" : (v.code == 4'hA) ? "R8" : (v.nwait != 0) ? "R7" : "R10";
        rtag   = (!fw && v.size != 2'd0) ? "R3" : "R5";

        @(negedge clk);
        req_kind = v.kind; req_addr = v.addr; req_size = v.size; req_wdata = v.wdata;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = poke;
        if (poke) begin
            req_kind = ~v.kind; req_addr = ~v.addr; req_wdata = ~v.wdata;
        end
        chk(!lframe_n && lad_oe && lad_out == st && !req_ready, "R2", "start nibble",
            {lframe_n, lad_oe, req_ready, lad_out}, {3'b010, st});
        for (int i = 0; i < hl; i++) begin
            @(negedge clk);
            if (!(lframe_n && lad_oe && lad_out == hn[i] && !req_ready)) bad_hdr++;
        end
        chk(bad_hdr == 0, fw ? "R4" : "R3", "header nibbles", bad_hdr, 0);
        if (wr) begin
            for (int i = 0; i < dl; i++) begin
                @(negedge clk);
                if (!(lad_oe && lad_out == v.wdata[4*i +: 4] && !req_ready)) bad_wd++;
            end
            chk(bad_wd == 0, fw ? "R5" : "R3", "write data nibbles", bad_wd, 0);
        end
        @(negedge clk);
        if (!(lad_oe && lad_out == 4'hF && lframe_n)) bad_tar++;
        @(negedge clk);
        if (lad_oe || !lframe_n) bad_tar++;
        chk(bad_tar == 0, "R6", "host turnaround", bad_tar, 0);
        nsync = to ? TMO : int'(v.nwait) + 1;
        for (int i = 0; i < nsync; i++) begin
            @(negedge clk);
            lad_in = (i < int'(v.nwait)) ? v.wcode : v.code;
            if (lad_oe || !lframe_n || req_ready) bad_quiet++;
        end
        if (to) begin
            for (int i = 0; i < ABORT; i++) begin
                @(negedge clk);
                lad_in = 4'hF;
                if (!(!lframe_n && lad_oe && lad_out == 4'hF)) bad_abort++;
                if (i == ABORT - 1) req_valid = 1'b0;
            end
            chk(bad_abort == 0, "R9", "abort frame", bad_abort, 0);
        end else begin
            if (!er && !wr) begin
                for (int i = 0; i < dl; i++) begin
                    @(negedge clk);
                    lad_in = v.tdata[4*i +: 4];
                    if (lad_oe || !lframe_n) bad_quiet++;
                end
            end
            for (int i = 0; i < 2; i++) begin
                @(negedge clk);
                lad_in = 4'hF;
                if (lad_oe || !lframe_n || req_ready) bad_quiet++;
                if (i == 1) req_valid = 1'b0;
            end
        end
        chk(bad_quiet == 0, "R6", "bus released by host", bad_quiet, 0);
        @(negedge clk);
        chk(rsp_done == 1'b1 && req_ready, dtag, "done pulse timing", {rsp_done, req_ready}, 2'b11);
        chk(rsp_error == er, dtag, "error flag", rsp_error, er);
        chk(rsp_rdata == exp_rd, rtag, "read data", rsp_rdata, exp_rd);
        @(negedge clk);
        chk(!rsp_done && lframe_n && !lad_oe, "R10", "single pulse, no stray cycle",
            {rsp_done, lframe_n, lad_oe}, 3'b010);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(lframe_n && !lad_oe && req_ready && !rsp_done, "R1", "reset state",
            {lframe_n, lad_oe, req_ready, rsp_done}, 4'b1010);
        rst = 1'b0;
        @(negedge clk);
        chk(lframe_n && !lad_oe && req_ready, "R1", "idle after reset",
            {lframe_n, lad_oe, req_ready}, 3'b101);

        for (int n = 0; n < NV; n++) run_vec(VT[n], (n == 1) || (n == 6));

        // R1: reset in the middle of a header
        req_kind = 2'd2; req_addr = 28'h0AB_CDEF; req_size = 2'd0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(lframe_n && !lad_oe && req_ready && !rsp_done, "R1", "mid-cycle reset",
            {lframe_n, lad_oe, req_ready, rsp_done}, 4'b1010);
        @(negedge clk);
        chk(lframe_n && !lad_oe && !rsp_done, "R1", "stays idle after reset",
            {lframe_n, lad_oe, rsp_done}, 3'b100);

        run_vec(VT[0], 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule